// File: doc/BRIEF.md
# Iterative Significand Multiplier

This block takes two single-precision floating-point words and forms the exact 48-bit product of their significands. It uses a small adder and a shift register rather than a full array multiplier. After a start request it consumes one bit of the first significand per clock. Each step conditionally adds the second significand into the upper half of a 49-bit accumulator, then shifts the accumulator right by one place.

Each product bit is final as soon as it drops out of the upper half. The block ORs the bits that fall in the low window into a sticky flag during the run, so no wide OR is needed at the end. Rounding logic downstream can use this flag directly.

If either operand is a zero, an infinity or a NaN, no iterations run. The block reports completion on the next cycle with a cleared result, so the normalize, round and exponent stages can apply their own special-case rules without spending 24 clocks of switching. Those stages sit outside this block.

Top module: `sigmul_iter`

## Requirements
- R1: Each operand's 24-bit significand is its 23-bit fraction with a hidden bit in bit 23. The hidden bit is 1 when the 8-bit exponent field (word bits 30:23) is nonzero, and 0 when that field is zero. A nonzero subnormal operand is multiplied, not bypassed.
- R2: After a full run, `product` equals the unsigned 48-bit product of the two significands.
- R3: With `product`, `sticky` equals the OR of product bits 21 down to 0.
- R4: `done` rises exactly 24 clock edges after the edge that accepts a non-special start. `busy` is high from the edge after acceptance until the edge that raises `done`, and is never high together with `done`.
- R5: If either operand has exponent field 0 and fraction 0, or exponent field all ones, an accepted start raises `done` on the next edge with `product` zero and `sticky` clear, and `busy` stays low.
- R6: `done` is high for exactly one cycle. `product` and `sticky` keep their values while the block is idle until the next accepted start.
- R7: A start asserted while `busy` is high is ignored, and its operands do not affect the running result.
- R8: A synchronous reset clears `busy`, `done`, `sticky` and `product`.
- R9: A start that is high in the cycle `done` is high is accepted, so back-to-back operations need no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a multiply with the present operands |
| op_a | input | 32 | First single-precision operand |
| op_b | input | 32 | Second single-precision operand |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 48 | Significand product |
| sticky | output | 1 | OR of product bits 21..0 |

## Verification
The assertions assume that reset is held across at least one rising edge and that `start` has a known value at every edge. They also assume the operands are known whenever `start` can be accepted, because the bypass decision and the loaded significands come straight from them. The stimulus drives every input shortly after a falling edge and holds reset for several cycles. It keeps operands defined at all times, including while `busy` is high, when deliberately conflicting starts are applied to show they are ignored.

// File: rtl/sigmul_pkg.sv
package sigmul_pkg;

    localparam int DEF_EXP_W  = 8;
    localparam int DEF_FRAC_W = 23;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/sigmul_opdec.sv
module sigmul_opdec #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int SIG_W = FRAC_W + 1
) (
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic [SIG_W-1:0]  sig_o,
    output logic              zero_o,
    output logic              nonfinite_o
);

    logic exp_nz;

    always_comb begin
        exp_nz      = |exp_i;
        // hidden bit follows the exponent field, subnormals get 0
        sig_o       = {exp_nz, frac_i};
        zero_o      = !exp_nz && (frac_i == '0);
        // infinity and NaN share the all-ones exponent
        nonfinite_o = &exp_i;
    end

endmodule

// File: rtl/sigmul_step.sv
module sigmul_step #(
    parameter int SIG_W = 24
) (
    input  logic [SIG_W-1:0] hi_i,
    input  logic [SIG_W-1:0] lo_i,
    input  logic [SIG_W-1:0] mpl_i,
    output logic [SIG_W-1:0] hi_o,
    output logic [SIG_W-1:0] lo_o,
    output logic             retired_o
);

    logic [SIG_W:0] sum;

    always_comb begin
        // add the multiplier significand when the current multiplicand bit is set
        sum       = {1'b0, hi_i} + (lo_i[0] ? {1'b0, mpl_i} : '0);
        // shift right: carry enters the top, sum LSB moves into the low half
        hi_o      = sum[SIG_W:1];
        lo_o      = {sum[0], lo_i[SIG_W-1:1]};
        retired_o = sum[0];
    end

endmodule

// File: rtl/sigmul_iter.sv
module sigmul_iter
    import sigmul_pkg::*;
#(
    parameter int EXP_W  = DEF_EXP_W,
    parameter int FRAC_W = DEF_FRAC_W,
    localparam int OP_W   = 1 + EXP_W + FRAC_W,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int PROD_W = 2 * SIG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic              busy,
    output logic              done,
    output logic [PROD_W-1:0] product,
    output logic              sticky
);

    localparam int CNT_W     = $clog2(SIG_W);
    localparam int STICKY_HI = PROD_W - SIG_W - 3;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(SIG_W - 1);

    typedef struct packed {
        phase_e             phase;
        logic               done;
        logic [CNT_W-1:0]   cnt;
        logic [SIG_W-1:0]   hi;
        logic [SIG_W-1:0]   lo;
        logic [SIG_W-1:0]   mpl;
        logic               sticky;
    } st_t;

    st_t st_d, st_q;

    // operand decode, one instance per operand (index 0 = op_a)
    logic [1:0][OP_W-1:0]  opnd;
    logic [1:0][SIG_W-1:0] sig;
    logic [1:0]            is_zero;
    logic [1:0]            is_nonfin;
    logic                  bypass;

    assign opnd = {op_b, op_a};

    for (genvar g = 0; g < 2; g++) begin : g_dec
        sigmul_opdec #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
        ) u_dec (
            .exp_i       (opnd[g][OP_W-2 -: EXP_W]),
            .frac_i      (opnd[g][FRAC_W-1:0]),
            .sig_o       (sig[g]),
            .zero_o      (is_zero[g]),
            .nonfinite_o (is_nonfin[g])
        );
    end

    assign bypass = (|is_zero) || (|is_nonfin);

    // one shift-add step
    logic [SIG_W-1:0] step_hi, step_lo;
    logic             step_bit;

    sigmul_step #(
        .SIG_W (SIG_W)
    ) u_step (
        .hi_i      (st_q.hi),
        .lo_i      (st_q.lo),
        .mpl_i     (st_q.mpl),
        .hi_o      (step_hi),
        .lo_o      (step_lo),
        .retired_o (step_bit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.cnt    = '0;
                    st_d.hi     = '0;
                    st_d.sticky = 1'b0;
                    if (bypass) begin
                        st_d.done = 1'b1;
                        st_d.lo   = '0;
                        st_d.mpl  = '0;
                    end else begin
                        st_d.phase = PH_RUN;
                        st_d.lo    = sig[0];
                        st_d.mpl   = sig[1];
                    end
                end
            end
            PH_RUN: begin
                st_d.hi = step_hi;
                st_d.lo = step_lo;
                // step k retires product bit k
                if (32'(st_q.cnt) <= STICKY_HI) begin
                    st_d.sticky = st_q.sticky | step_bit;
                end
                if (st_q.cnt == LAST_STEP) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = (st_q.phase == PH_RUN);
    assign done    = st_q.done;
    assign product = {st_q.hi, st_q.lo};
    assign sticky  = st_q.sticky;

    // ---------------- assertions ----------------
    logic [CNT_W:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    // R4
    run_length_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done && (32'(run_len) == SIG_W)));

    // R5
    early_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && bypass) |=> (done && !busy && (product == '0) && !sticky));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(product) && $stable(sticky)));

    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && start && (32'(run_len) < SIG_W - 1)) |=> busy);

endmodule

// File: tb/sigmul_iter_tb.sv
module sigmul_iter_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        busy, done, sticky;
    logic [47:0] product;

    always #5 clk = ~clk;

    sigmul_iter dut_i (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .op_a    (op_a),
        .op_b    (op_b),
        .busy    (busy),
        .done    (done),
        .product (product),
        .sticky  (sticky)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    int    cyc    = 0;
    string cur_req = "R8";

    // ---------------- behavioural reference ----------------
    function automatic logic [23:0] ref_sig(input logic [31:0] w);
        return {(w[30:23] != 8'd0), w[22:0]};
    endfunction

    function automatic bit ref_special(input logic [31:0] w);
        return ((w[30:23] == 8'd0) && (w[22:0] == 23'd0)) || (w[30:23] == 8'hFF);
    endfunction

    logic        m_busy = 1'b0, m_done = 1'b0, m_sticky = 1'b0;
    logic [47:0] m_prod = '0, m_res = '0;
    int          m_left = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy   <= 1'b0;
            m_done   <= 1'b0;
            m_prod   <= '0;
            m_sticky <= 1'b0;
            m_left   <= 0;
        end else begin
            m_done <= 1'b0;
            if (m_busy) begin
                m_left <= m_left - 1;
                if (m_left == 1) begin
                    m_busy   <= 1'b0;
                    m_done   <= 1'b1;
                    m_prod   <= m_res;
                    m_sticky <= (m_res[21:0] != 22'd0);
                end
            end else if (start) begin
                if (ref_special(op_a) || ref_special(op_b)) begin
                    m_done   <= 1'b1;
                    m_prod   <= '0;
                    m_sticky <= 1'b0;
                end else begin
                    m_busy <= 1'b1;
                    m_left <= 24;
                    m_res  <= 48'(longint'(ref_sig(op_a)) * longint'(ref_sig(op_b)));
                end
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        n_chk++;
        if (busy !== m_busy) begin
            n_fail++;
            $display("FAIL R4 (%s) busy actual=%b expected=%b", cur_req, busy, m_busy);
        end
        n_chk++;
        if (done !== m_done) begin
            n_fail++;
            $display("FAIL R4/%s done actual=%b expected=%b", cur_req, done, m_done);
        end
        if (!m_busy) begin
            n_chk++;
            if (product !== m_prod) begin
                n_fail++;
                $display("FAIL %s product actual=%h expected=%h", cur_req, product, m_prod);
            end
            n_chk++;
            if (sticky !== m_sticky) begin
                n_fail++;
                $display("FAIL R3 (%s) sticky actual=%b expected=%b", cur_req, sticky, m_sticky);
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic mul(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk); #1;
        op_a  = a;
        op_b  = b;
        start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        while (m_busy) @(negedge clk);
        idle(2);
    endtask

    function automatic logic [31:0] rnd_normal();
        logic [7:0] e;
        e = 8'($urandom_range(1, 254));
        return {1'($urandom), e, 23'($urandom)};
    endfunction

    initial begin
        idle(4);
        #1 rst = 1'b0;
        cur_req = "R8";
        idle(3);

        cur_req = "R2";
        mul(32'h3F80_0000, 32'h3F80_0000);   // 1.0 * 1.0
        mul(32'h3FFF_FFFF, 32'h7F7F_FFFF);   // all-ones fractions
        mul(32'hC040_0001, 32'h3F80_0003);   // low bits set: sticky
        mul(32'h4000_0000, 32'hBF40_0000);   // exact, sticky clear

        cur_req = "R1";
        mul(32'h0000_0001, 32'h3F80_0000);   // smallest subnormal
        mul(32'h007F_FFFF, 32'h0040_0000);   // two subnormals
        mul(32'h8080_0000, 32'h0000_0003);   // smallest normal x subnormal

        cur_req = "R5";
        mul(32'h0000_0000, 32'h3F80_0000);   // zero
        mul(32'h3FC0_0000, 32'h8000_0000);   // negative zero
        mul(32'h7F80_0000, 32'h4000_0000);   // infinity
        mul(32'h4000_0000, 32'h7FC0_0001);   // NaN
        mul(32'hFF80_0000, 32'h0000_0000);   // infinity x zero

        cur_req = "R6";
        mul(32'h4049_0FDB, 32'h3FB5_04F3);
        idle(10);                            // outputs must hold

        // R7: starts during the run with other operands
        cur_req = "R7";
        @(negedge clk); #1;
        op_a = 32'h3F80_0001; op_b = 32'h3F80_0001; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        idle(4); #1;
        op_a = 32'h7F80_0000; op_b = 32'h4123_4567; start = 1'b1;
        idle(3); #1;
        start = 1'b0;
        while (m_busy) @(negedge clk);
        idle(2);

        // R9: start held high across done
        cur_req = "R9";
        @(negedge clk); #1;
        op_a = 32'h3F90_1234; op_b = 32'h40A0_0F0F; start = 1'b1;
        @(negedge clk); #1;
        while (!m_done) @(negedge clk);
        #1 op_a = 32'h3FFF_0000; op_b = 32'h3F81_0001;
        @(negedge clk); #1;
        start = 1'b0;
        while (m_busy) @(negedge clk);
        idle(2);

        // R8: reset in the middle of a run
        cur_req = "R8";
        @(negedge clk); #1;
        op_a = 32'h3FAB_CDEF; op_b = 32'h3F12_3456; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        idle(6); #1;
        rst = 1'b1;
        idle(2); #1;
        rst = 1'b0;
        idle(3);

        cur_req = "R2";
        for (int i = 0; i < 40; i++) begin
            logic [31:0] a, b;
            a = rnd_normal();
            b = ((i % 5) == 0) ? {1'b0, 8'd0, 23'($urandom)} : rnd_normal();
            mul(a, b);
        end

        idle(3);
        finish_run();
    end

endmodule